// File: doc/BRIEF.md
# Signed Sequential Restoring Divider

This block divides a 32-bit two's complement dividend by a 16-bit two's complement divisor and returns a 16-bit quotient truncated toward zero. It produces one quotient bit per clock. A rising edge on `go` captures both operands. Each operand is reduced to its magnitude, and the block records whether the two signs differ. Sixteen restoring shift-and-subtract steps then run on a 32-bit partial-remainder register, using its upper half as the working remainder. A final cycle applies the sign and raises `done`.

A zero divisor skips the step loop entirely. In that case the block reports an all-ones quotient after a single cycle. Once `done` is high, the result stays put until the next rising edge of `go`. A rising edge of `go` that arrives while a division is running is ignored.

The quotient is exact when two conditions hold: the divisor magnitude is below 2^15, and the dividend magnitude is below the divisor magnitude times 2^16. The result is then the truncated signed quotient reduced modulo 2^16.

Top module: `sdiv_seq`

## Requirements
- R1: While `rst_n` is low, and after a reset that interrupts a division, `done` is 0 and `quot` is 0.
- R2: A division starts on a clock edge that sees `go` high when it was low at the previous edge, provided the block is idle or finished. `done` reads 0 after that edge.
- R3: With a nonzero divisor, `done` goes high exactly 17 clock edges after the edge that started the division: 16 step cycles, then one sign cycle.
- R4: For non-negative operands within the operating range (|divisor| < 2^15, |dividend| < |divisor|·2^16), `quot` equals floor(dividend / divisor) modulo 2^16 when `done` is high.
- R5: For operands of any sign within the operating range, the division uses magnitudes. The quotient is negated (two's complement) when exactly one operand is negative, so the result truncates toward zero.
- R6: With a zero divisor, `done` goes high 1 clock edge after the starting edge and `quot` is 16'hFFFF.
- R7: While `done` is high and `go` does not rise, `done` stays high and `quot` stays unchanged. Holding `go` high does not restart a division.
- R8: A rising edge of `go` during the 16 step cycles is ignored. The running division completes with its original operands and latency.
- R9: Range edges give exact results: divisor ±1, a quotient of 0, a quotient of 16'h8000 and a quotient magnitude of 65535.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start request; a rising edge starts a division |
| divisor_in | input | 16 | Signed divisor, sampled at the starting edge |
| dividend_in | input | 32 | Signed dividend, sampled at the starting edge |
| quot | output | 16 | Signed quotient, valid while `done` is high |
| done | output | 1 | High when `quot` holds a finished result |

## Verification
The remainder-bound assertion assumes that every division started with a nonzero divisor lies in the operating range. In that range the upper half of the partial remainder stays strictly below the divisor magnitude throughout the step cycles. Every vector and directed case in the stimulus is chosen inside that range, including its extremes: a divisor of 32767 with dividend 2147418111, and a dividend of -32768 over 1. The zero-divisor cases bypass the step cycles, so they fall outside the bound and never reach it.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2,
        ST_HOLD = 2'd3
    } sdiv_state_e;
endpackage

// File: rtl/sdiv_mag.sv
module sdiv_mag #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    output logic         neg,
    output logic [W-1:0] mag
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        neg = val[W-1];
        mag = neg ? (~val + ONE) : val;
    end
endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
    parameter int DV_W = 16
) (
    input  logic [2*DV_W-1:0] rem_in,
    input  logic [DV_W-1:0]   dv,
    input  logic [DV_W-1:0]   q_in,
    output logic [2*DV_W-1:0] rem_out,
    output logic [DV_W-1:0]   q_out
);
    localparam int DD_W = 2 * DV_W;

    logic [DD_W-1:0] shifted;
    logic [DV_W-1:0] trial;

    always_comb begin
        shifted = {rem_in[DD_W-2:0], 1'b0};
        trial   = shifted[DD_W-1:DV_W] - dv;
        if (!trial[DV_W-1]) begin
            rem_out = {trial, shifted[DV_W-1:0]};
            q_out   = {q_in[DV_W-2:0], 1'b1};
        end else begin
            // restore: keep the shifted remainder untouched
            rem_out = shifted;
            q_out   = {q_in[DV_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/sdiv_seq.sv
module sdiv_seq
    import sdiv_pkg::*;
#(
    parameter int DV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [DV_W-1:0]   divisor_in,
    input  logic [2*DV_W-1:0] dividend_in,
    output logic [DV_W-1:0]   quot,
    output logic              done
);
    localparam int DD_W  = 2 * DV_W;
    localparam int CNT_W = $clog2(DV_W);
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(DV_W - 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [DV_W-1:0]  Q_ONE   = DV_W'(1);

    typedef struct packed {
        sdiv_state_e      st;
        logic             go_prev;
        logic [CNT_W-1:0] cnt;
        logic [DD_W-1:0]  rem;
        logic [DV_W-1:0]  dv;
        logic [DV_W-1:0]  q;
        logic             flip;
        logic             zero;
        logic             done;
    } regs_t;

    regs_t r_q, r_d;

    logic            dv_neg, dd_neg;
    logic [DV_W-1:0] dv_mag;
    logic [DD_W-1:0] dd_mag;
    logic [DD_W-1:0] step_rem;
    logic [DV_W-1:0] step_q;
    logic            start_w;

    sdiv_mag #(.W(DV_W)) u_dv_mag (.val(divisor_in),  .neg(dv_neg), .mag(dv_mag));
    sdiv_mag #(.W(DD_W)) u_dd_mag (.val(dividend_in), .neg(dd_neg), .mag(dd_mag));

    sdiv_step #(.DV_W(DV_W)) u_step (
        .rem_in (r_q.rem),
        .dv     (r_q.dv),
        .q_in   (r_q.q),
        .rem_out(step_rem),
        .q_out  (step_q)
    );

    always_comb begin
        start_w   = go && !r_q.go_prev &&
                    (r_q.st == ST_IDLE || r_q.st == ST_HOLD);
        r_d       = r_q;
        r_d.go_prev = go;
        case (r_q.st)
            ST_IDLE, ST_HOLD: begin
                if (start_w) begin
                    r_d.done = 1'b0;
                    r_d.dv   = dv_mag;
                    r_d.rem  = dd_mag;
                    r_d.q    = '0;
                    r_d.flip = dv_neg ^ dd_neg;
                    r_d.zero = (divisor_in == '0);
                    r_d.cnt  = '0;
                    r_d.st   = (divisor_in == '0) ? ST_FIN : ST_RUN;
                end
            end
            ST_RUN: begin
                r_d.rem = step_rem;
                r_d.q   = step_q;
                r_d.cnt = r_q.cnt + CNT_ONE;
                if (r_q.cnt == LAST) r_d.st = ST_FIN;
            end
            ST_FIN: begin
                if (r_q.zero)      r_d.q = '1;
                else if (r_q.flip) r_d.q = ~r_q.q + Q_ONE;
                r_d.done = 1'b1;
                r_d.st   = ST_HOLD;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign quot = r_q.q;
    assign done = r_q.done;

    // R2
    done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> !done);

    // R3
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && r_q.cnt == LAST) |=> (r_q.st == ST_FIN));

    // R3
    done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(r_q.st) == ST_FIN));

    // R4
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN) |-> (r_q.rem[DD_W-1:DV_W] < r_q.dv));

    // R6
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_w && divisor_in == '0) |-> ##2 (done && quot == '1));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HOLD && !start_w) |=> (done && $stable(quot)));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RUN && r_q.cnt != LAST) |=>
            (r_q.st == ST_RUN && r_q.cnt == $past(r_q.cnt) + CNT_ONE));
endmodule

// File: tb/sdiv_seq_tb.sv
module sdiv_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [15:0] divisor_in = '0;
    logic [31:0] dividend_in = '0;
    logic [15:0] quot;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;

    localparam int NV = 12;
    localparam logic [31:0] VDD [NV] = '{
        32'd100, -32'sd100, 32'd100, -32'sd100, 32'd123456789, 32'd5,
        32'd32767, -32'sd32768, 32'd2147418111, -32'sd150000, 32'd7, 32'd0};
    localparam logic [15:0] VDV [NV] = '{
        16'd7, 16'd7, -16'sd7, -16'sd7, 16'd12345, 16'd9,
        16'd1, 16'd1, 16'd32767, -16'sd3, -16'sd1, 16'd5};

    sdiv_seq u_dut (
        .clk(clk), .rst_n(rst_n), .go(go),
        .divisor_in(divisor_in), .dividend_in(dividend_in),
        .quot(quot), .done(done)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] ref_q(input logic [31:0] a, input logic [15:0] b);
        longint la = longint'($signed(a));
        longint lb = longint'($signed(b));
        longint q = la / lb;
        return 16'(q);
    endfunction

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // start at a negedge, return after done rises; latency counted in edges after the start edge
    task automatic run_op(input logic [31:0] dd, input logic [15:0] dv,
                          input logic [15:0] exp_q, input int exp_lat, input string tag);
        int lat = 0;
        @(negedge clk);
        dividend_in = dd; divisor_in = dv; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(done == 1'b0, {"R2 done low after start ", tag}, done, 0);
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, {"R3/R6 latency ", tag}, lat, exp_lat);
        chk(quot == exp_q, {"R4 R5 R9 quotient ", tag}, quot, exp_q);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done in reset", done, 0);
        chk(quot == 16'h0, "R1 quot in reset", quot, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R1 done after reset", done, 0);

        // table of vectors: R4 R5 R9
        for (int i = 0; i < NV; i++) begin
            run_op(VDD[i], VDV[i], ref_q(VDD[i], VDV[i]), 17, $sformatf("vec %0d", i));
        end

        // R6 zero divisor, both dividend signs
        run_op(-32'sd77, 16'd0, 16'hFFFF, 1, "R6 zero neg");
        run_op(32'd12345, 16'd0, 16'hFFFF, 1, "R6 zero pos");

        // R7 go held high: no restart, result stable
        begin
            int lat = 0;
            @(negedge clk);
            dividend_in = 32'd100; divisor_in = 16'd7; go = 1'b1;
            @(negedge clk);
            while (!done && lat < 40) begin
                @(negedge clk);
                lat++;
            end
            chk(lat == 17, "R7 latency with go held", lat, 17);
            dividend_in = 32'd9; divisor_in = 16'd3;
            repeat (6) @(negedge clk);
            chk(done == 1'b1, "R7 done held", done, 1);
            chk(quot == 16'd14, "R7 quot held", quot, 14);
            go = 1'b0;
            repeat (3) @(negedge clk);
            chk(quot == 16'd14 && done, "R7 quot held after go low", quot, 14);
        end

        // R8 rising go during a run is ignored
        begin
            int lat = 0;
            @(negedge clk);
            dividend_in = 32'd1000; divisor_in = 16'd10; go = 1'b1;
            @(negedge clk);
            go = 1'b0;
            repeat (4) begin @(negedge clk); lat++; end
            dividend_in = 32'd9; divisor_in = 16'd3; go = 1'b1;
            @(negedge clk); lat++;
            go = 1'b0;
            while (!done && lat < 40) begin
                @(negedge clk);
                lat++;
            end
            chk(lat == 17, "R8 latency unchanged", lat, 17);
            chk(quot == 16'd100, "R8 quotient of first operands", quot, 100);
        end

        // R1 reset in the middle of a division
        @(negedge clk);
        dividend_in = -32'sd500; divisor_in = 16'd4; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R1 done after mid-run reset", done, 0);
        chk(quot == 16'h0, "R1 quot after mid-run reset", quot, 0);
        rst_n = 1'b1;
        run_op(-32'sd500, 16'd4, 16'hFF83, 17, "R5 after reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule